// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the control and status word of a floating-point coprocessor. The integer pipeline reads it and writes it through a small control-register port. An index selects the register. Only one index maps to real storage; every other index reads as zero and ignores writes. The word holds the following fields:

- the 2-bit rounding mode
- a flush control bit
- five exception enables
- five sticky flags
- the cause bits of the last operation
- eight condition-code bits

When the arithmetic datapath completes an operation, it presents that operation's exception set to the block. The block rewrites the cause bits and accumulates the sticky flags. If any exception of that operation is enabled, the block raises a trap request in the same cycle and withholds permission to write back the result. A comparison can also write one condition-code bit, unless the same operation traps.

Top module: `fcsr_unit`

## Requirements
- R1: After synchronous reset the whole status word reads as zero, and `trap_req` is low while no operation or write is presented.
- R2: Reading control index 31 returns the status word combinationally. Reading index 0, or any other index, returns zero.
- R3: A write to index 31 stores only these bits of the write data: 24 (flush), 11:7 (enables), 6:2 (sticky flags) and 1:0 (rounding mode). Every other stored bit keeps its value.
- R4: A write to any index other than 31 leaves the status word unchanged.
- R5: A completed operation replaces the cause field 16:12 with its exceptions. The order is inexact at bit 0, underflow 1, overflow 2, divide-by-zero 3 and invalid 4, both at `op_exc` and within the field. The operation also clears bit 17.
- R6: Each exception of an operation sets the matching sticky bit at 6:2, in the same order as the cause field. Operations never clear sticky bits; only a status write can clear them.
- R7: When `op_fused` is high, the divide-by-zero input is ignored for both the cause bit and the sticky bit.
- R8: While an operation is presented, `trap_req` is high and `wb_enable` is low in that same cycle if any of its exceptions has its enable set. The enable for a cause bit sits five positions below it. Otherwise `wb_enable` is high and `trap_req` is low.
- R9: A status write whose resulting enables line up with an already stored cause bit raises `trap_req` in the cycle of the write.
- R10: A non-trapping operation with `cc_we` high writes `cc_val` into condition code `cc_sel`. Code 0 is held at bit 23 and code k (k from 1 to 7) at bit 24+k. The `cc_flags` output presents codes 0 to 7 in index order. An operation that traps leaves the codes unchanged.
- R11: When an operation and a status write arrive in the same cycle, the operation is applied and the write is dropped.
- R12: `rnd_mode` always shows bits 1:0 of the status word, and `flush_en` shows bit 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel | input | 5 | Control-register read index |
| rd_data | output | 32 | Combinational read data |
| wr_en | input | 1 | Control-register write strobe |
| wr_sel | input | 5 | Control-register write index |
| wr_data | input | 32 | Write data |
| op_done | input | 1 | An arithmetic operation completes this cycle |
| op_exc | input | 5 | Exceptions of that operation (I,U,O,Z,V from bit 0) |
| op_fused | input | 1 | Operation is of multiply-add type |
| cc_we | input | 1 | Operation is a compare that writes a condition code |
| cc_sel | input | 3 | Condition-code index |
| cc_val | input | 1 | Compare result |
| wb_enable | output | 1 | Result may be written to the destination register |
| trap_req | output | 1 | An enabled exception is pending |
| rnd_mode | output | 2 | Current rounding mode |
| flush_en | output | 1 | Current flush control |
| cc_flags | output | 8 | Condition codes 0 to 7 |

## Verification
`trap_req`, `wb_enable` and `rd_data` are combinational. The bench therefore samples them one time unit after driving the inputs on the falling edge, inside the same cycle as the stimulus. Status-word updates land on the next rising edge. Each write or operation task holds its inputs for exactly one rising edge and clears them on the falling edge that follows. The task then reads index 31 and the mirror outputs on that falling edge, where the updated value has been visible for half a cycle. Expected words come from a running model kept in the bench, built from the field positions given in the requirements.

// File: rtl/fcsr_pkg.sv
// Package: field layout of the floating-point control/status word and
// helpers shared by the sub-blocks. Assumes a 32-bit word with five
// IEEE exception kinds and eight condition codes.
package fcsr_pkg;
    localparam int CSR_W     = 32;
    localparam int NUM_EXC   = 5;
    localparam int NUM_CC    = 8;
    localparam int CC_IDX_W  = $clog2(NUM_CC);
    localparam int RM_W      = 2;

    // Field positions; the enable-to-cause spacing is what the trap rule uses.
    localparam int RM_LSB     = 0;
    localparam int STK_LSB    = RM_LSB + RM_W;
    localparam int ENA_LSB    = STK_LSB + NUM_EXC;
    localparam int CAU_LSB    = ENA_LSB + NUM_EXC;
    localparam int UNIMPL_BIT = CAU_LSB + NUM_EXC;
    localparam int CC0_BIT    = 23;
    localparam int FLUSH_BIT  = 24;
    localparam int CCHI_LSB   = FLUSH_BIT + 1;

    // Exception positions inside each five-bit field.
    localparam int EXC_INEXACT = 0;
    localparam int EXC_UNDER   = 1;
    localparam int EXC_OVER    = 2;
    localparam int EXC_DIVZ    = 3;
    localparam int EXC_INVAL   = 4;

    // Mask of the bits a software write may change.
    function automatic logic [CSR_W-1:0] sw_write_mask();
        logic [CSR_W-1:0] m;
        m = '0;
        m[FLUSH_BIT] = 1'b1;
        m[RM_LSB +: RM_W] = '1;
        m[STK_LSB +: NUM_EXC] = '1;
        m[ENA_LSB +: NUM_EXC] = '1;
        return m;
    endfunction
endpackage

// File: rtl/fcsr_write_merge.sv
// Module: merges software write data into the current status word.
// Only masked bits take the new value; all others keep the stored value.
// Assumes the caller has already decided that the write is accepted.
module fcsr_write_merge
    import fcsr_pkg::*;
#(
    parameter int W = CSR_W
) (
    input  logic [W-1:0] cur_word,
    input  logic [W-1:0] wr_word,
    output logic [W-1:0] next_word
);
    localparam logic [W-1:0] MASK = W'(sw_write_mask());

    // Bitwise select between written and retained bits.
    always_comb begin
        next_word = (wr_word & MASK) | (cur_word & ~MASK);
    end
endmodule

// File: rtl/fcsr_exc_merge.sv
// Module: filters the exceptions of one completed operation into new
// cause bits and compares them with the enables to find a trap.
// Assumes a fused (multiply-add) operation cannot report divide-by-zero.
module fcsr_exc_merge
    import fcsr_pkg::*;
#(
    parameter int N_EXC = NUM_EXC,
    parameter int DIVZ  = EXC_DIVZ
) (
    input  logic [N_EXC-1:0] exc_in,
    input  logic             fused,
    input  logic [N_EXC-1:0] enables,
    output logic [N_EXC-1:0] cause_out,
    output logic             trap_hit
);
    logic [N_EXC-1:0] hit;

    for (genvar i = 0; i < N_EXC; i++) begin : g_flag
        if (i == DIVZ) begin : g_divz
            // Drop divide-by-zero for fused operations.
            always_comb cause_out[i] = exc_in[i] & ~fused;
        end else begin : g_plain
            // Pass the exception through unchanged.
            always_comb cause_out[i] = exc_in[i];
        end
        // An exception traps only when its enable is set.
        always_comb hit[i] = cause_out[i] & enables[i];
    end

    // Any enabled exception requests a trap.
    always_comb trap_hit = |hit;
endmodule

// File: rtl/fcsr_cc_bank.sv
// Module: next-state of the condition-code bank. Writes one code selected
// by index when enabled and holds all others. Assumes at most one code
// changes per cycle.
module fcsr_cc_bank
    import fcsr_pkg::*;
#(
    parameter int N_CC  = NUM_CC,
    parameter int SEL_W = CC_IDX_W
) (
    input  logic [N_CC-1:0]  cc_cur,
    input  logic             cc_wr,
    input  logic [SEL_W-1:0] cc_idx,
    input  logic             cc_bit,
    output logic [N_CC-1:0]  cc_next
);
    for (genvar k = 0; k < N_CC; k++) begin : g_cc
        // Replace code k only when it is the addressed one.
        always_comb begin
            if (cc_wr && (cc_idx == SEL_W'(k)))
                cc_next[k] = cc_bit;
            else
                cc_next[k] = cc_cur[k];
        end
    end
endmodule

// File: rtl/fcsr_unit.sv
// Module: floating-point control/status register. Serves control-register
// reads and writes, takes per-operation exception results, keeps the
// cause and sticky fields, and raises trap requests. Assumes combinational
// reads, a synchronous active-low reset, and that a completed operation
// wins over a software write presented in the same cycle.
module fcsr_unit
    import fcsr_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter int STATUS_SEL = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_sel,
    output logic [CSR_W-1:0]    rd_data,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_sel,
    input  logic [CSR_W-1:0]    wr_data,
    input  logic                op_done,
    input  logic [NUM_EXC-1:0]  op_exc,
    input  logic                op_fused,
    input  logic                cc_we,
    input  logic [CC_IDX_W-1:0] cc_sel,
    input  logic                cc_val,
    output logic                wb_enable,
    output logic                trap_req,
    output logic [RM_W-1:0]     rnd_mode,
    output logic                flush_en,
    output logic [NUM_CC-1:0]   cc_flags
);
    localparam logic [IDX_W-1:0] SEL = IDX_W'(STATUS_SEL);

    logic [CSR_W-1:0]   csr_q;
    logic [CSR_W-1:0]   wr_next;
    logic [CSR_W-1:0]   op_next;
    logic [NUM_EXC-1:0] op_cause;
    logic               op_hit;
    logic               op_trap;
    logic               status_wr;
    logic               wr_trap;
    logic [NUM_CC-1:0]  cc_cur;
    logic [NUM_CC-1:0]  cc_next;

    // Gather the scattered condition-code bits in index order.
    always_comb begin
        cc_cur[0] = csr_q[CC0_BIT];
        cc_cur[NUM_CC-1:1] = csr_q[CCHI_LSB +: NUM_CC-1];
    end

    fcsr_exc_merge #(.N_EXC(NUM_EXC), .DIVZ(EXC_DIVZ)) u_exc (
        .exc_in    (op_exc),
        .fused     (op_fused),
        .enables   (csr_q[ENA_LSB +: NUM_EXC]),
        .cause_out (op_cause),
        .trap_hit  (op_hit)
    );

    fcsr_write_merge #(.W(CSR_W)) u_wr (
        .cur_word  (csr_q),
        .wr_word   (wr_data),
        .next_word (wr_next)
    );

    fcsr_cc_bank #(.N_CC(NUM_CC), .SEL_W(CC_IDX_W)) u_cc (
        .cc_cur  (cc_cur),
        .cc_wr   (op_done & cc_we & ~op_hit),
        .cc_idx  (cc_sel),
        .cc_bit  (cc_val),
        .cc_next (cc_next)
    );

    // Trap and write-back permission for the operation in flight.
    always_comb begin
        op_trap   = op_done & op_hit;
        wb_enable = op_done & ~op_hit;
    end

    // Accept a status write only when no operation competes for the word.
    always_comb begin
        status_wr = wr_en && (wr_sel == SEL) && !op_done;
        wr_trap   = status_wr &&
                    |(wr_next[CAU_LSB +: NUM_EXC] & wr_next[ENA_LSB +: NUM_EXC]);
        trap_req  = op_trap | wr_trap;
    end

    // Build the word after an operation: new cause, merged sticky, codes.
    always_comb begin
        op_next = csr_q;
        op_next[CAU_LSB +: NUM_EXC] = op_cause;
        op_next[UNIMPL_BIT] = 1'b0;
        op_next[STK_LSB +: NUM_EXC] = csr_q[STK_LSB +: NUM_EXC] | op_cause;
        op_next[CC0_BIT] = cc_next[0];
        op_next[CCHI_LSB +: NUM_CC-1] = cc_next[NUM_CC-1:1];
    end

    // Status word storage with operation priority over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            csr_q <= '0;
        else if (op_done)
            csr_q <= op_next;
        else if (status_wr)
            csr_q <= wr_next;
    end

    // Combinational read port and field mirrors.
    always_comb begin
        rd_data  = (rd_sel == SEL) ? csr_q : '0;
        rnd_mode = csr_q[RM_LSB +: RM_W];
        flush_en = csr_q[FLUSH_BIT];
        cc_flags = cc_cur;
    end
endmodule

// File: rtl/fcsr_unit_chk.sv
// Checker: temporal properties of the status word, bound into fcsr_unit.
module fcsr_unit_chk
    import fcsr_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter int STATUS_SEL = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_done,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_sel,
    input logic             trap_req,
    input logic             wb_enable,
    input logic [CSR_W-1:0] csr_q
);
    localparam logic [CSR_W-1:0] MASK = sw_write_mask();

    // R6
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> ((csr_q[STK_LSB +: NUM_EXC] & $past(csr_q[STK_LSB +: NUM_EXC]))
                     == $past(csr_q[STK_LSB +: NUM_EXC])));

    // R8
    trap_blocks_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && trap_req) |-> !wb_enable);

    // R4
    foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !op_done && wr_sel != IDX_W'(STATUS_SEL)) |=> $stable(csr_q));

    // R3
    write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !op_done) |=> ((csr_q & ~MASK) == $past(csr_q & ~MASK)));

    // R5
    unimpl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !csr_q[UNIMPL_BIT]);

    // R11
    op_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && wr_en) |=> ((csr_q & MASK & ~(CSR_W'(((1 << NUM_EXC) - 1)) << STK_LSB))
                               == $past(csr_q & MASK & ~(CSR_W'(((1 << NUM_EXC) - 1)) << STK_LSB))));
endmodule

bind fcsr_unit fcsr_unit_chk #(.IDX_W(IDX_W), .STATUS_SEL(STATUS_SEL)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_done   (op_done),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .trap_req  (trap_req),
    .wb_enable (wb_enable),
    .csr_q     (csr_q)
);

// File: tb/test_fcsr_unit.sv
module test_fcsr_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_sel = 5'd31;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        op_fused = 1'b0;
    logic        cc_we = 1'b0;
    logic [2:0]  cc_sel = '0;
    logic        cc_val = 1'b0;
    logic        wb_enable, trap_req, flush_en;
    logic [1:0]  rnd_mode;
    logic [7:0]  cc_flags;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcsr_unit i_fcsr_unit (
        .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_data(rd_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .op_done(op_done), .op_exc(op_exc), .op_fused(op_fused),
        .cc_we(cc_we), .cc_sel(cc_sel), .cc_val(cc_val),
        .wb_enable(wb_enable), .trap_req(trap_req), .rnd_mode(rnd_mode),
        .flush_en(flush_en), .cc_flags(cc_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_word(input string req, input logic [31:0] exp);
        rd_sel = 5'd31;
        #1;
        check(req, rd_data, exp);
    endtask

    // One status-register write; checks the trap output during the write.
    task automatic do_write(input logic [4:0] sel, input logic [31:0] data,
                            input logic exp_trap, input string req);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        #1;
        check(req, 32'(trap_req), 32'(exp_trap));
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One completed operation; checks trap and write-back in its cycle.
    task automatic do_op(input logic [4:0] exc, input logic fused, input logic ccw,
                         input logic [2:0] ccs, input logic ccv,
                         input logic exp_trap, input string req);
        op_done = 1'b1; op_exc = exc; op_fused = fused;
        cc_we = ccw; cc_sel = ccs; cc_val = ccv;
        #1;
        check(req, 32'(trap_req), 32'(exp_trap));
        check(req, 32'(wb_enable), 32'(!exp_trap));
        @(posedge clk);
        @(negedge clk);
        op_done = 1'b0; op_exc = '0; op_fused = 1'b0; cc_we = 1'b0;
    endtask

    task automatic t_reset();
        check_word("R1 reset word", 32'h0);
        check("R1 trap idle", 32'(trap_req), 32'h0);
    endtask

    task automatic t_read_index();
        do_write(5'd31, 32'hFFFF_FFFF, 1'b0, "R3 full write");
        check_word("R3 masked store", 32'h0100_0FFF);
        check("R12 rnd_mode", 32'(rnd_mode), 32'h3);
        check("R12 flush_en", 32'(flush_en), 32'h1);
        rd_sel = 5'd0; #1;
        check("R2 index 0 reads zero", rd_data, 32'h0);
        rd_sel = 5'd9; #1;
        check("R2 other index reads zero", rd_data, 32'h0);
        do_write(5'd31, 32'h0, 1'b0, "R3 clear write");
        check_word("R3 cleared", 32'h0);
    endtask

    task automatic t_foreign_write();
        do_write(5'd7, 32'h0100_0FFF, 1'b0, "R4 foreign write");
        check_word("R4 word unchanged", 32'h0);
    endtask

    task automatic t_cause_sticky();
        do_op(5'b00101, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R5 op I+O");
        check_word("R5 cause I+O", 32'h0000_5014);
        do_op(5'b01000, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R6 op Z");
        check_word("R6 sticky accumulates", 32'h0000_8034);
        do_op(5'b11000, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, "R7 fused op");
        check_word("R7 fused drops divzero", 32'h0001_0074);
        do_write(5'd31, 32'h0, 1'b0, "R6 software clear");
        check_word("R6 sticky cleared, cause kept", 32'h0001_0000);
    endtask

    task automatic t_traps();
        do_write(5'd31, 32'h0000_0800, 1'b1, "R9 enable meets cause");
        check_word("R9 word after write", 32'h0001_0800);
        do_op(5'b10000, 1'b0, 1'b1, 3'd3, 1'b1, 1'b1, "R8 enabled invalid");
        check_word("R10 trap blocks code write", 32'h0001_0840);
        check("R10 codes unchanged", 32'(cc_flags), 32'h0);
        do_write(5'd31, 32'h0, 1'b0, "R9 no enable no trap");
        check_word("R3 word after clear", 32'h0001_0000);
    endtask

    task automatic t_cond_codes();
        do_op(5'b00000, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, "R10 cc0 set");
        check_word("R10 cc0 at bit 23", 32'h0080_0000);
        do_op(5'b00000, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0, "R10 cc5 set");
        check_word("R10 cc5 at bit 29", 32'h2080_0000);
        check("R10 cc_flags", 32'(cc_flags), 32'h21);
        do_op(5'b00000, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, "R10 cc0 clear");
        check_word("R10 cc0 cleared", 32'h2000_0000);
    endtask

    task automatic t_collision();
        op_done = 1'b1; op_exc = 5'b00001;
        wr_en = 1'b1; wr_sel = 5'd31; wr_data = 32'h0000_0FFF;
        #1;
        check("R11 no trap on collision", 32'(trap_req), 32'h0);
        @(posedge clk);
        @(negedge clk);
        op_done = 1'b0; op_exc = '0; wr_en = 1'b0;
        check_word("R11 write dropped", 32'h2000_1004);
        do_write(5'd31, 32'h0000_0002, 1'b0, "R12 rm write");
        check_word("R12 word", 32'h2000_1002);
        check("R12 rnd_mode follows", 32'(rnd_mode), 32'h2);
        check("R12 flush off", 32'(flush_en), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_index();
        t_foreign_write();
        t_cause_sticky();
        t_traps();
        t_cond_codes();
        t_collision();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule